// File: doc/BRIEF.md
# Phase Lock Detector

This block is a digital lock indicator for a phase-locked loop. It runs on a fast sampling clock and watches the up and down pulses that the phase/frequency detector produces. For each comparison period it counts the sampling-clock cycles in which either pulse is active. A strobe at the reference rate closes each period. When the period closes, the measured width is compared against a window. The window is chosen from four widths.

A run counter tracks how many comparisons in a row fell inside the window. When the run reaches a threshold chosen from four values, the lock output rises. One comparison outside the window drops lock at once and restarts the run. The same comparison also sets a sticky loss flag. That flag stays set until the surrounding logic pulses a clear input. While the charge-pump reset control is active, the detector is frozen: no comparison is judged, the run is held at zero and lock stays low.

Top module: `phase_lock_detector`

## Requirements
- R1: After a synchronous reset, `locked` and `unlock_seen` are both 0.
- R2: The width of a period is the number of clock cycles in which `up_pulse` or `dn_pulse` is high. A period covers the cycles from the one after the previous `cmp_evt` up to and including the cycle in which `cmp_evt` is high. A cycle with both pulses high counts once. A comparison is inside the window only when this width is strictly less than the window limit.
- R3: The window limit is `WIN_BASE` × 2^`win_sel` clock cycles. Code 0 is the narrowest window and code 3 the widest.
- R4: `cnt_sel` codes 0, 1, 2 and 3 require 2^(5−`CNT_SHRINK`), 2^(8−`CNT_SHRINK`), 2^(10−`CNT_SHRINK`) and 2^(12−`CNT_SHRINK`) consecutive inside comparisons. `locked` rises in the clock after the edge that judges the last of them. `locked` stays high while further inside comparisons arrive. Cycles without `cmp_evt` leave it unchanged.
- R5: A comparison outside the window clears `locked` on the next clock. It also restarts the run, so a full set of consecutive inside comparisons is needed again before lock.
- R6: An outside comparison sets `unlock_seen` on the next clock. The flag stays set until `unlock_clr` is high on a clock edge with no outside comparison. If both happen on the same edge, the set wins.
- R7: While `cp_hold` is high, `cmp_evt` and the pulse inputs are ignored. The run is zeroed, `locked` is 0 after the next clock and `unlock_seen` is unchanged. Pulse activity during the hold does not count toward the first period after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| up_pulse | input | 1 | Detector up pulse, sampled each clock |
| dn_pulse | input | 1 | Detector down pulse, sampled each clock |
| cmp_evt | input | 1 | One-cycle strobe that closes a comparison period |
| cp_hold | input | 1 | Charge-pump reset: freezes the detector |
| win_sel | input | 2 | Window width select |
| cnt_sel | input | 2 | Consecutive-comparison count select |
| unlock_clr | input | 1 | Clears the sticky loss flag |
| locked | output | 1 | Lock flag |
| unlock_seen | output | 1 | Sticky loss-of-lock flag |

## Verification
The bench builds the block with `WIN_BASE` = 3 and `CNT_SHRINK` = 3. This gives windows of 3, 6, 12 and 24 cycles and run targets of 4, 32, 128 and 512 comparisons. Every count-select code can then be driven to its exact boundary, one comparison short and exactly on target, in a few thousand cycles. The small base puts the at-limit width and the just-below width within a short period. That makes the strict-less-than window edge cheap to probe for each window code.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [1:0] {
        CMP_NONE    = 2'd0,
        CMP_INSIDE  = 2'd1,
        CMP_OUTSIDE = 2'd2
    } cmp_verdict_e;

    typedef struct packed {
        logic [SEL_W-1:0] win_sel;
        logic [SEL_W-1:0] cnt_sel;
    } ld_cfg_t;

    function automatic int window_limit(input int base, input logic [SEL_W-1:0] sel);
        return base << sel;
    endfunction

    function automatic int run_exponent(input logic [SEL_W-1:0] sel, input int shrink);
        int e;
        case (sel)
            2'd0:    e = 5;
            2'd1:    e = 8;
            2'd2:    e = 10;
            default: e = 12;
        endcase
        return e - shrink;
    endfunction

    function automatic int run_target(input logic [SEL_W-1:0] sel, input int shrink);
        return 1 << run_exponent(sel, shrink);
    endfunction

endpackage

// File: rtl/lockdet_width_meter.sv
module lockdet_width_meter
    import lockdet_pkg::*;
#(
    parameter int WIN_BASE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             up_pulse,
    input  logic             dn_pulse,
    input  logic             cmp_evt,
    input  logic [SEL_W-1:0] win_sel,
    output cmp_verdict_e     verdict
);
    localparam int LIMIT_MAX = WIN_BASE << 3;
    localparam int WW        = $clog2(LIMIT_MAX + 1);

    logic [WW-1:0] acc;
    logic [WW-1:0] limit;
    logic [WW-1:0] width_now;
    logic          active;

    always_comb begin
        limit  = WW'(window_limit(WIN_BASE, win_sel));
        active = up_pulse | dn_pulse;
        // saturate once the limit is reached: the verdict is already decided
        if (acc >= limit) width_now = acc;
        else              width_now = acc + WW'(active);
    end

    always_comb begin
        if (hold || !cmp_evt)       verdict = CMP_NONE;
        else if (width_now < limit) verdict = CMP_INSIDE;
        else                        verdict = CMP_OUTSIDE;
    end

    always_ff @(posedge clk) begin
        if (rst || hold || cmp_evt) acc <= '0;
        else                        acc <= width_now;
    end

    // R2: every judged period leaves a clean accumulator for the next one
    p_period_restart_r2: assert property (@(posedge clk) disable iff (rst)
        (cmp_evt && !hold) |=> (acc == '0));

    // R7: a held detector carries no width into the first period after it
    p_hold_flushes_r7: assert property (@(posedge clk) disable iff (rst)
        hold |=> (acc == '0));

endmodule

// File: rtl/lockdet_run_tracker.sv
module lockdet_run_tracker
    import lockdet_pkg::*;
#(
    parameter int CNT_SHRINK = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  cmp_verdict_e     verdict,
    input  logic [SEL_W-1:0] cnt_sel,
    output logic             locked
);
    localparam int RUN_MAX = 1 << (12 - CNT_SHRINK);
    localparam int RW      = $clog2(RUN_MAX + 1);

    logic [RW-1:0] run;
    logic [RW-1:0] run_inc;
    logic [RW-1:0] target;

    always_comb begin
        target  = RW'(run_target(cnt_sel, CNT_SHRINK));
        run_inc = (run == RW'(RUN_MAX)) ? run : run + RW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            run    <= '0;
            locked <= 1'b0;
        end else begin
            case (verdict)
                CMP_INSIDE: begin
                    run    <= run_inc;
                    locked <= (run_inc >= target);
                end
                CMP_OUTSIDE: begin
                    run    <= '0;
                    locked <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R4: lock only ever rises on the back of an inside comparison
    p_lock_on_inside_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(verdict) == CMP_INSIDE));

    // R4: quiet cycles leave the lock state alone
    p_idle_keeps_lock_r4: assert property (@(posedge clk) disable iff (rst)
        (verdict == CMP_NONE && !hold) |=> $stable(locked));

    // R5: one outside comparison drops lock and the run together
    p_outside_drops_r5: assert property (@(posedge clk) disable iff (rst)
        (verdict == CMP_OUTSIDE) |=> (!locked && run == '0));

    // R7: charge-pump reset forces the unlocked state
    p_hold_unlocks_r7: assert property (@(posedge clk) disable iff (rst)
        hold |=> (!locked && run == '0));

endmodule

// File: rtl/lockdet_loss_latch.sv
module lockdet_loss_latch
    import lockdet_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  cmp_verdict_e verdict,
    input  logic         clr,
    output logic         flag
);
    always_ff @(posedge clk) begin
        if (rst)                             flag <= 1'b0;
        else if (verdict == CMP_OUTSIDE)     flag <= 1'b1;
        else if (clr)                        flag <= 1'b0;
    end

    // R6: an outside comparison is always recorded
    p_outside_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (verdict == CMP_OUTSIDE) |=> flag);

    // R6: without a clear the flag never falls
    p_flag_sticks_r6: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/phase_lock_detector.sv
module phase_lock_detector
    import lockdet_pkg::*;
#(
    parameter int WIN_BASE   = 4,
    parameter int CNT_SHRINK = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       up_pulse,
    input  logic       dn_pulse,
    input  logic       cmp_evt,
    input  logic       cp_hold,
    input  logic [1:0] win_sel,
    input  logic [1:0] cnt_sel,
    input  logic       unlock_clr,
    output logic       locked,
    output logic       unlock_seen
);
    ld_cfg_t      cfg;
    cmp_verdict_e verdict;

    assign cfg.win_sel = win_sel;
    assign cfg.cnt_sel = cnt_sel;

    lockdet_width_meter #(.WIN_BASE(WIN_BASE)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .hold     (cp_hold),
        .up_pulse (up_pulse),
        .dn_pulse (dn_pulse),
        .cmp_evt  (cmp_evt),
        .win_sel  (cfg.win_sel),
        .verdict  (verdict)
    );

    lockdet_run_tracker #(.CNT_SHRINK(CNT_SHRINK)) u_tracker (
        .clk     (clk),
        .rst     (rst),
        .hold    (cp_hold),
        .verdict (verdict),
        .cnt_sel (cfg.cnt_sel),
        .locked  (locked)
    );

    lockdet_loss_latch u_loss (
        .clk     (clk),
        .rst     (rst),
        .verdict (verdict),
        .clr     (unlock_clr),
        .flag    (unlock_seen)
    );

    // R1: both flags come out of reset low
    p_reset_clean_r1: assert property (@(posedge clk)
        rst |=> (!locked && !unlock_seen));

endmodule

// File: tb/phase_lock_detector_test.sv
module phase_lock_detector_test;
    localparam int WB = 3;
    localparam int SH = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, up, dn, cmp, hold, clr;
    logic [1:0] ws, cs;
    logic locked, seen;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    phase_lock_detector #(.WIN_BASE(WB), .CNT_SHRINK(SH)) uut (
        .clk(clk), .rst(rst), .up_pulse(up), .dn_pulse(dn), .cmp_evt(cmp),
        .cp_hold(hold), .win_sel(ws), .cnt_sel(cs), .unlock_clr(clr),
        .locked(locked), .unlock_seen(seen)
    );

    typedef struct packed {
        logic [1:0] win;
        logic [1:0] cnt;
        int         width;
        int         mode;
        int         periods;
        logic       exp_lock;
    } vec_t;

    // windows 3/6/12/24, targets 4/32/128/512
    localparam vec_t VECS [9] = '{
        '{2'd0, 2'd0, 2,  0, 3,  1'b0},   // R4 one short
        '{2'd0, 2'd0, 2,  0, 4,  1'b1},   // R4 exact
        '{2'd0, 2'd0, 3,  0, 10, 1'b0},   // R2 width at limit is outside
        '{2'd0, 2'd0, 2,  2, 4,  1'b1},   // R2 both pulses count once
        '{2'd1, 2'd0, 5,  1, 4,  1'b1},   // R3 window 6
        '{2'd1, 2'd0, 6,  1, 4,  1'b0},   // R3 window 6 edge
        '{2'd3, 2'd1, 23, 0, 31, 1'b0},   // R3/R4 window 24, target 32
        '{2'd3, 2'd1, 23, 0, 32, 1'b1},   // R4 target 32
        '{2'd2, 2'd0, 0,  0, 4,  1'b1}    // R2 zero width
    };

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic period(input int width, input int mode, input bit clr_at_cmp);
        int len = width + 2;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            up  = (mode != 1) && (i < width);
            dn  = (mode != 0) && (i < width);
            cmp = (i == len - 1);
            clr = clr_at_cmp && (i == len - 1);
        end
        @(negedge clk);
        up = 0; dn = 0; cmp = 0; clr = 0;
    endtask

    task automatic run(input int n, input int width, input int mode);
        for (int k = 0; k < n; k++) period(width, mode, 1'b0);
    endtask

    task automatic restart();
        @(negedge clk); hold = 1;
        @(negedge clk); hold = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; up = 0; dn = 0; cmp = 0; hold = 0; clr = 0; ws = 0; cs = 0;
        repeat (3) @(negedge clk);
        check(locked, 1'b0, "R1 locked after reset");
        check(seen,   1'b0, "R1 unlock_seen after reset");
        rst = 0;

        // table walk
        for (int v = 0; v < 9; v++) begin
            ws = VECS[v].win;
            cs = VECS[v].cnt;
            restart();
            run(VECS[v].periods, VECS[v].width, VECS[v].mode);
            check(locked, VECS[v].exp_lock, $sformatf("R2/R3/R4 vector %0d", v));
        end

        // R4 exact boundary for count code 2 (128) and code 3 (512)
        ws = 0; cs = 2; restart();
        run(127, 1, 0);
        check(locked, 1'b0, "R4 code2 at 127");
        run(1, 1, 0);
        check(locked, 1'b1, "R4 code2 at 128");
        cs = 3; restart();
        run(511, 0, 0);
        check(locked, 1'b0, "R4 code3 at 511");
        run(1, 0, 0);
        check(locked, 1'b1, "R4 code3 at 512");
        repeat (5) @(negedge clk);
        check(locked, 1'b1, "R4 idle cycles keep lock");

        // R5/R6 loss of lock
        cs = 0; pulse_clr();
        check(seen, 1'b0, "R6 cleared before loss");
        restart(); run(4, 1, 0);
        check(locked, 1'b1, "R5 locked before loss");
        period(8, 1, 1'b0);
        check(locked, 1'b0, "R5 first outside drops lock");
        check(seen,   1'b1, "R6 outside sets sticky");
        run(3, 1, 0);
        check(locked, 1'b0, "R5 run restarted, 3 inside");
        check(seen,   1'b1, "R6 sticky holds without clear");
        run(1, 1, 0);
        check(locked, 1'b1, "R5 relock at 4th");
        pulse_clr();
        check(seen, 1'b0, "R6 clear drops sticky");
        period(5, 0, 1'b1);
        check(seen, 1'b1, "R6 set wins over clear");
        pulse_clr();
        check(seen, 1'b0, "R6 cleared again");

        // R7 charge-pump hold
        restart(); run(4, 1, 0);
        check(locked, 1'b1, "R7 locked before hold");
        @(negedge clk); hold = 1; up = 1;
        repeat (3) @(negedge clk);
        cmp = 1;
        @(negedge clk); cmp = 0;
        repeat (3) @(negedge clk);
        hold = 0; up = 0;
        check(locked, 1'b0, "R7 hold drops lock");
        check(seen,   1'b0, "R7 hold ignores outside-width comparison");
        run(1, 2, 0);
        check(seen, 1'b0, "R7 no width carried from hold");
        run(2, 2, 0);
        check(locked, 1'b0, "R7 run restarted after hold");
        run(1, 2, 0);
        check(locked, 1'b1, "R7 lock after full run post hold");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule